// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches a shared 16-bit free-running count and compares it against five independent 16-bit compare values. The count itself lives outside the block: the block receives its current value and a one-cycle step strobe that marks the cycle in which the count has just taken a new value. When a stepped count equals a channel's compare value, that channel's event flag is set and stays set until software clears it by writing a one to its bit.

Software loads the compare values one byte at a time, sets a per-channel interrupt enable in an 8-bit enable register, and clears flags by writing ones to an 8-bit flag register. The flag and the enable of a channel sit at the same bit position. Each channel raises its own interrupt request while its flag and its enable are both set, and one combined request is the OR of all five.

Each channel's flag is a two-state machine. CH_IDLE is the cleared state; the transition MATCH (a stepped count equal to the compare value) moves it to CH_HIT. CH_HIT returns to CH_IDLE on the transition CLEAR (a one written to its flag bit), unless a MATCH arrives in the same cycle, in which case it stays in CH_HIT.

Top module: `ocu_compare_unit`

## Requirements
- R1: After reset every flag and every enable is zero, no interrupt request is active, and every compare value is 0xFFFF, so stepping the count to 0xFFFF sets all five flags.
- R2: Compare value of channel k (k = 1..5) is written as a high byte at address 2(k-1) and a low byte at address 2(k-1)+1; a flag is set in the cycle after a stepped count equals the full 16-bit value.
- R3: Channel 1 uses flag and enable bit 7, channel 2 bit 6, down to channel 5 at bit 3; bits 2:0 of the flag register (address 11) and the enable register (address 10) always read as zero.
- R4: A compare value of 0x0000 is matched when the count steps from 0xFFFF to 0x0000.
- R5: A match is taken only in a cycle with the step strobe high; a count held at the compare value without a step, or a compare value written equal to the current count, sets no flag.
- R6: Writing the flag register clears exactly the bits written as one; bits written as zero are unchanged and ones on clear bits have no effect.
- R7: When a clear and a match for the same channel fall in the same cycle, the flag ends up set.
- R8: irq_ch[k-1] is high exactly while channel k's flag and enable are both set, irq_any is the OR of the five, and with all enables zero no request is raised.
- R9: A compare byte written in the same cycle as a step takes part only in comparisons of later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Current free-running count |
| cnt_step | input | 1 | High in the cycle cnt_val has just advanced |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Byte address: 0..9 compare bytes, 10 enables, 11 flags |
| wr_data | input | 8 | Write data |
| flag_q | output | 8 | Flag register, channel 1 in bit 7 |
| mask_q | output | 8 | Enable register, channel 1 in bit 7 |
| irq_ch | output | 5 | Per-channel request, bit 0 is channel 1 |
| irq_any | output | 1 | OR of all channel requests |

## Verification
The bench aims at the wrap through zero, where a design using a magnitude or window test instead of exact equality on the stepped value would miss or double-fire the match. It holds the count at a matching value with no step and writes a compare equal to the held count, which a design comparing every cycle would flag repeatedly. It lands a flag clear and a match in one cycle, where a clear-priority design would lose the event, and writes a compare byte in the same cycle as a step, where a design forwarding the new byte would match early. It also mixes set and clear bits in one clear write, catching a design that writes the flag register instead of clearing ones.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 8;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_HIT  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/ocu_cmp_slot.sv
module ocu_cmp_slot #(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_hi,
    input  logic                      wr_lo,
    input  logic [ocu_pkg::BYTE_W-1:0] wr_byte,
    input  logic [CNT_W-1:0]          cnt_val,
    input  logic                      cnt_step,
    output logic                      hit_o
);
    localparam int LO_W = ocu_pkg::BYTE_W;
    localparam int HI_W = CNT_W - LO_W;

    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else begin
            if (wr_hi) cmp_q[CNT_W-1:LO_W] <= wr_byte[HI_W-1:0];
            if (wr_lo) cmp_q[LO_W-1:0]     <= wr_byte;
        end
    end

    // Exact equality, taken only on the step cycle; uses the value held
    // before any write in the same cycle.
    always_comb hit_o = cnt_step && (cnt_val == cmp_q);

    // R2: a low-byte write lands in the register one cycle later
    a_r2_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cmp_q[LO_W-1:0] == $past(wr_byte)));
endmodule

// File: rtl/ocu_flag_fsm.sv
module ocu_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import ocu_pkg::*;

    ch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (set_i)           state_d = CH_HIT;
            CH_HIT:  if (clr_i && !set_i) state_d = CH_IDLE;
            default:                      state_d = CH_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == CH_HIT);

    // R7: a match always leaves the flag set, even with a clear
    a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R6: a clear without a match drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R5: no flag appears without a match
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/ocu_compare_unit.sv
module ocu_compare_unit #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        flag_q,
    output logic [7:0]        mask_q,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);
    localparam int TOP_BIT = ocu_pkg::REG_W - 1;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(2 * NUM_CH);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * NUM_CH + 1);

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] ch_flag;
    logic [NUM_CH-1:0] ch_en_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hi_w, wr_lo_w;
        assign wr_hi_w = wr_en && (wr_addr == ADDR_W'(2 * i));
        assign wr_lo_w = wr_en && (wr_addr == ADDR_W'(2 * i + 1));
        assign clr[i]  = wr_en && (wr_addr == FLAG_ADDR) && wr_data[TOP_BIT - i];

        ocu_cmp_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hi    (wr_hi_w),
            .wr_lo    (wr_lo_w),
            .wr_byte  (wr_data),
            .cnt_val  (cnt_val),
            .cnt_step (cnt_step),
            .hit_o    (hit[i])
        );

        ocu_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hit[i]),
            .clr_i  (clr[i]),
            .flag_o (ch_flag[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en_q <= '0;
        end else if (wr_en && (wr_addr == MASK_ADDR)) begin
            for (int i = 0; i < NUM_CH; i++) ch_en_q[i] <= wr_data[TOP_BIT - i];
        end
    end

    always_comb begin
        flag_q = '0;
        mask_q = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            flag_q[TOP_BIT - i] = ch_flag[i];
            mask_q[TOP_BIT - i] = ch_en_q[i];
        end
        irq_ch  = ch_flag & ch_en_q;
        irq_any = |irq_ch;
    end

    // R8: with every enable clear, no request leaves the block
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq_any);
endmodule

// File: tb/ocu_compare_unit_tb_top.sv
module ocu_compare_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_step = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  flag_q, mask_q;
    logic [4:0]  irq_ch;
    logic        irq_any;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ocu_compare_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_step(cnt_step),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_q(flag_q), .mask_q(mask_q), .irq_ch(irq_ch), .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: optional step and optional write in the same cycle
    task automatic cyc(input logic stp, input logic [15:0] v,
                       input logic we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cnt_step = stp;
        if (stp) cnt_val = v;
        wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        cnt_step = 1'b0; wr_en = 1'b0;
    endtask

    task automatic step(input logic [15:0] v);
        cyc(1'b1, v, 1'b0, 4'd0, 8'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b0, 16'd0, 1'b1, a, d);
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        wr(4'(2 * (ch - 1)), v[15:8]);
        wr(4'(2 * (ch - 1) + 1), v[7:0]);
    endtask

    task automatic t_reset();
        chk("R1 flags", {24'd0, flag_q}, 32'h00);
        chk("R1 enables", {24'd0, mask_q}, 32'h00);
        chk("R1 irq", {26'd0, irq_any, irq_ch}, 32'h0);
        step(16'hFFFE);
        chk("R1 no match below FFFF", {24'd0, flag_q}, 32'h00);
        step(16'hFFFF);
        chk("R1 reset compare FFFF", {24'd0, flag_q}, 32'hF8);
        wr(4'd11, 8'hFF);
        chk("R6 clear all", {24'd0, flag_q}, 32'h00);
    endtask

    task automatic t_map();
        set_cmp(3, 16'h1234);
        step(16'h1233);
        chk("R2 no early match", {24'd0, flag_q}, 32'h00);
        step(16'h1234);
        chk("R3 ch3 at bit5", {24'd0, flag_q}, 32'h20);
        set_cmp(1, 16'h00AA);
        step(16'h00AA);
        chk("R2 ch1 at bit7", {24'd0, flag_q}, 32'hA0);
    endtask

    task automatic t_w1c();
        wr(4'd11, 8'h60);
        chk("R6 only written set bits clear", {24'd0, flag_q}, 32'h80);
        wr(4'd11, 8'h07);
        chk("R3 low bits no effect", {24'd0, flag_q}, 32'h80);
        wr(4'd11, 8'h80);
        chk("R6 clear last", {24'd0, flag_q}, 32'h00);
    endtask

    task automatic t_hold();
        step(16'h1234);
        chk("R5 match sets", {24'd0, flag_q}, 32'h20);
        wr(4'd11, 8'h20);
        repeat (5) cyc(1'b0, 16'd0, 1'b0, 4'd0, 8'd0);
        chk("R5 held count no rematch", {24'd0, flag_q}, 32'h00);
        set_cmp(2, 16'h1234);
        chk("R5 compare equal to held count", {24'd0, flag_q}, 32'h00);
    endtask

    task automatic t_wrap();
        set_cmp(5, 16'h0000);
        step(16'hFFFF);
        wr(4'd11, 8'hFF);
        step(16'h0000);
        chk("R4 wrap to zero matches ch5", {24'd0, flag_q}, 32'h08);
        wr(4'd11, 8'h08);
    endtask

    task automatic t_race();
        wr(4'd11, 8'hFF);
        cyc(1'b1, 16'h00AA, 1'b1, 4'd11, 8'h80);
        chk("R7 match beats clear", {24'd0, flag_q}, 32'h80);
        wr(4'd11, 8'hFF);
        wr(4'd6, 8'h00);
        cyc(1'b1, 16'h0050, 1'b1, 4'd7, 8'h50);
        chk("R9 same-cycle write not used", {24'd0, flag_q}, 32'h00);
        step(16'h0050);
        chk("R9 new value used later", {24'd0, flag_q}, 32'h10);
        wr(4'd11, 8'hFF);
    endtask

    task automatic t_irq();
        step(16'h1234);
        chk("R8 flags ch2 ch3", {24'd0, flag_q}, 32'h60);
        chk("R8 no irq with enables off", {26'd0, irq_any, irq_ch}, 32'h0);
        wr(4'd10, 8'hFF);
        chk("R3 enable low bits zero", {24'd0, mask_q}, 32'hF8);
        chk("R8 all enabled", {26'd0, irq_any, irq_ch}, 32'h26);
        wr(4'd10, 8'h40);
        chk("R8 ch2 only", {26'd0, irq_any, irq_ch}, 32'h22);
        wr(4'd10, 8'h80);
        chk("R8 ch1 enabled flag clear", {26'd0, irq_any, irq_ch}, 32'h0);
        wr(4'd10, 8'h00);
        chk("R8 enables off again", {26'd0, irq_any, irq_ch}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_w1c();
        t_hold();
        t_wrap();
        t_race();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule